// File: doc/BRIEF.md
# Gate-Kill Fault Shutdown

This block sits between a three-phase PWM generator and the gate drivers of an inverter. It passes six phase switch commands and one brake command through a polarity stage, and it turns off the power stage when an external fault line goes low. The active-low gate-kill line is synchronised and then qualified by a counter that must see a programmable number of consecutive low samples. Once qualified, the block latches a fault flag and drives all six phase outputs to their inactive level. They stay there until the host clears the flag while the kill line is high again.

A second active-low line, the brake kill, is synchronised but neither filtered nor latched. It turns off only the brake output, for as long as it is low. The host sets the polarity of each output group and the filter length through a single-cycle configuration write. After reset the phase group is high-true, the brake is low-true and the filter length is 32.

Top module: `gate_kill_shutdown`

## Requirements
- R1: After reset, fault_o is 0 and the filter length is 32. The phase group is high-true, so phase_o equals pwm_i. The brake is low-true, so brake_o equals the inverse of brake_i.
- R2: With no fault, phase_o is pwm_i XOR {6{phase_lt}} and brake_o is brake_i XOR NOT brake_ht. The polarity bits are written by cfg_we_i: cfg_phase_lt_i=1 makes the phases low-true, and cfg_brake_ht_i=1 makes the brake high-true. The new polarity shows on the outputs after the write edge.
- R3: When gk_ni is low for N consecutive clocks (N being the filter length), fault_o rises and all six phase outputs go to the inactive level. That level is 0 when high-true and 1 when low-true. This happens on the (N+2)th rising edge after gk_ni falls, which includes a two-stage synchroniser. For N=32 that is 34 clocks.
- R4: A gk_ni low pulse of N-1 clocks leaves fault_o at 0 and the outputs following their inputs.
- R5: The filter length is written through cfg_filt_len_i. A value of 0 behaves as 1.
- R6: fault_o and the phase shutdown stay latched after gk_ni returns high. A clr_i pulse clears them on the next edge only when the synchronised gk_ni is high. A clear while gk_ni is low has no effect.
- R7: When bk_ni is low, brake_o goes to its inactive level (1 when low-true, 0 when high-true) on the second rising edge. phase_o and fault_o are unaffected.
- R8: A gate-kill fault does not change brake_o.
- R9: During a fault, the phase outputs follow the current polarity: after a polarity write they move to the new inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| pwm_i | input | 6 | phase switch commands, 1 = switch on |
| brake_i | input | 1 | brake switch command, 1 = on |
| gk_ni | input | 1 | active-low gate-kill fault line |
| bk_ni | input | 1 | active-low brake-kill line |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_phase_lt_i | input | 1 | phase group low-true when 1 |
| cfg_brake_ht_i | input | 1 | brake high-true when 1 |
| cfg_filt_len_i | input | 8 | gate-kill filter length in clocks |
| clr_i | input | 1 | fault flag clear |
| phase_o | output | 6 | phase gate outputs |
| brake_o | output | 1 | brake gate output |
| fault_o | output | 1 | latched gate-kill fault flag |

## Verification
The polarity path is tried with a table of complementary and mixed phase patterns under all four polarity combinations. This separates a correct XOR from a dropped inversion or a swapped group. The filter is probed with a low pulse one clock short of the limit and one exactly at it, at the default length, a short length and length zero. This separates an off-by-one count and a missing saturation. Clears are issued both while the kill line is low and after it rises, so that a latch that follows the line or ignores the gating can be seen. The brake kill is asserted during normal running and the gate kill during brake activity, to show that each acts only on its own output.

// File: rtl/gks_pkg.sv
package gks_pkg;
  localparam int unsigned NPH      = 6;
  localparam int unsigned FILT_W   = 8;
  localparam int unsigned FILT_DEF = 32;
  localparam int unsigned SYNC_N   = 2;

  typedef struct packed {
    logic              phase_lt;
    logic              brake_ht;
    logic [FILT_W-1:0] filt_len;
  } gks_cfg_t;

  localparam gks_cfg_t CFG_RST = '{phase_lt: 1'b0, brake_ht: 1'b0,
                                   filt_len: FILT_W'(FILT_DEF)};
endpackage

// File: rtl/gks_sync.sv
module gks_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // resets to 1: kill lines idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/gks_filter.sv
module gks_filter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         low_i,
  input  logic [W-1:0] len_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_d, limit;

  assign limit = (len_i == '0) ? W'(1) : len_i;

  always_comb begin
    if (!low_i)              cnt_d = '0;
    else if (cnt_q >= limit) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign hit_o = low_i && (cnt_d >= limit);
endmodule

// File: rtl/gks_out_stage.sv
module gks_out_stage #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] cmd_i,
  input  logic         low_true_i,
  input  logic         kill_i,
  output logic [N-1:0] gate_o
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    assign gate_o[i] = kill_i ? low_true_i : (cmd_i[i] ^ low_true_i);
  end
endmodule

// File: rtl/gate_kill_shutdown.sv
module gate_kill_shutdown
  import gks_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPH-1:0]    pwm_i,
  input  logic              brake_i,
  input  logic              gk_ni,
  input  logic              bk_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_phase_lt_i,
  input  logic              cfg_brake_ht_i,
  input  logic [FILT_W-1:0] cfg_filt_len_i,
  input  logic              clr_i,
  output logic [NPH-1:0]    phase_o,
  output logic              brake_o,
  output logic              fault_o
);
  gks_cfg_t cfg_q;
  logic     gk_s, bk_s, gk_hit, fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (cfg_we_i) cfg_q <= '{phase_lt: cfg_phase_lt_i,
                                  brake_ht: cfg_brake_ht_i,
                                  filt_len: cfg_filt_len_i};
  end

  gks_sync #(.STAGES(SYNC_N)) u_gk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gk_ni), .q_o(gk_s));
  gks_sync #(.STAGES(SYNC_N)) u_bk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bk_ni), .q_o(bk_s));

  gks_filter #(.W(FILT_W)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .low_i(!gk_s),
    .len_i(cfg_q.filt_len), .hit_o(gk_hit));

  // qualification wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            fault_q <= 1'b0;
    else if (gk_hit)        fault_q <= 1'b1;
    else if (clr_i && gk_s) fault_q <= 1'b0;
  end

  gks_out_stage #(.N(NPH)) u_phase (
    .cmd_i(pwm_i), .low_true_i(cfg_q.phase_lt),
    .kill_i(fault_q), .gate_o(phase_o));

  logic [0:0] brake_v;
  gks_out_stage #(.N(1)) u_brake (
    .cmd_i(brake_i), .low_true_i(!cfg_q.brake_ht),
    .kill_i(!bk_s), .gate_o(brake_v));

  assign brake_o = brake_v[0];
  assign fault_o = fault_q;
endmodule

// File: rtl/gate_kill_shutdown_chk.sv
module gate_kill_shutdown_chk
  import gks_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           gk_ni,
  input logic           clr_i,
  input logic           fault_o,
  input logic [NPH-1:0] phase_o
);
  p_rise_needs_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> !$past(gk_ni, 2));

  p_kill_uniform_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (phase_o == '0 || phase_o == '1));

  p_fault_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !clr_i |=> fault_o);

  p_clear_needs_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(clr_i));
endmodule

bind gate_kill_shutdown gate_kill_shutdown_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gk_ni(gk_ni), .clr_i(clr_i),
  .fault_o(fault_o), .phase_o(phase_o));

// File: tb/tb_gate_kill_shutdown.sv
module tb_gate_kill_shutdown;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [5:0] pwm_i = '0;
  logic       brake_i = 1'b0, gk_ni = 1'b1, bk_ni = 1'b1;
  logic       cfg_we_i = 1'b0, cfg_phase_lt_i = 1'b0, cfg_brake_ht_i = 1'b0;
  logic [7:0] cfg_filt_len_i = 8'd32;
  logic       clr_i = 1'b0;
  logic [5:0] phase_o;
  logic       brake_o, fault_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gate_kill_shutdown dut (.*);

  // {lt, ht, pwm[5:0], brake, exp_phase[5:0], exp_brake}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b0, 6'b101101, 1'b1, 6'b101101, 1'b0},
    {1'b0, 1'b0, 6'b010010, 1'b0, 6'b010010, 1'b1},
    {1'b1, 1'b0, 6'b101101, 1'b1, 6'b010010, 1'b0},
    {1'b1, 1'b1, 6'b000000, 1'b0, 6'b111111, 1'b0},
    {1'b0, 1'b1, 6'b111111, 1'b1, 6'b111111, 1'b1},
    {1'b1, 1'b1, 6'b110001, 1'b1, 6'b001110, 1'b1}
  };

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(logic lt, logic ht, logic [7:0] len);
    cfg_phase_lt_i = lt; cfg_brake_ht_i = ht; cfg_filt_len_i = len;
    cfg_we_i = 1'b1; tick(1); cfg_we_i = 1'b0;
  endtask

  task automatic clear;
    clr_i = 1'b1; tick(1); clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    pwm_i = 6'b110100; brake_i = 1'b1;
    tick(2); rst_ni = 1'b1; tick(1);
    // R1 reset state
    chk("R1 fault", {7'd0, fault_o}, 8'd0);
    chk("R1 phase", {2'b0, phase_o}, {2'b0, 6'b110100});
    chk("R1 brake", {7'd0, brake_o}, 8'd0);

    // R2 polarity table
    foreach (VEC[i]) begin
      cfg(VEC[i][15], VEC[i][14], 8'd32);
      pwm_i = VEC[i][13:8]; brake_i = VEC[i][7];
      tick(0);
      chk("R2 phase", {2'b0, phase_o}, {2'b0, VEC[i][6:1]});
      chk("R2 brake", {7'd0, brake_o}, {7'd0, VEC[i][0]});
    end

    cfg(1'b0, 1'b0, 8'd32);
    pwm_i = 6'b011011; brake_i = 1'b1;
    // R4 pulse one short
    gk_ni = 1'b0; tick(31); gk_ni = 1'b1; tick(5);
    chk("R4 fault", {7'd0, fault_o}, 8'd0);
    chk("R4 phase", {2'b0, phase_o}, {2'b0, 6'b011011});

    // R3 exact length, default 32
    gk_ni = 1'b0; tick(33);
    chk("R3 before", {7'd0, fault_o}, 8'd0);
    tick(1);
    chk("R3 fault", {7'd0, fault_o}, 8'd1);
    chk("R3 phase", {2'b0, phase_o}, 8'd0);
    // R8 brake unaffected by fault
    chk("R8 brake", {7'd0, brake_o}, 8'd0);
    brake_i = 1'b0; tick(0);
    chk("R8 brake follow", {7'd0, brake_o}, 8'd1);
    // R9 polarity change during kill
    cfg(1'b1, 1'b0, 8'd32);
    chk("R9 phase", {2'b0, phase_o}, {2'b0, 6'b111111});
    // R6 clear while low ignored
    clear; tick(1);
    chk("R6 clr low", {7'd0, fault_o}, 8'd1);
    gk_ni = 1'b1; tick(4);
    chk("R6 latched", {7'd0, fault_o}, 8'd1);
    clear;
    chk("R6 cleared", {7'd0, fault_o}, 8'd0);
    chk("R6 phase", {2'b0, phase_o}, {2'b0, 6'b100100});

    // R5 short filter length 3
    cfg(1'b0, 1'b0, 8'd3);
    gk_ni = 1'b0; tick(4);
    chk("R5 len3 before", {7'd0, fault_o}, 8'd0);
    tick(1);
    chk("R5 len3 fault", {7'd0, fault_o}, 8'd1);
    gk_ni = 1'b1; tick(3); clear;
    chk("R5 len3 clr", {7'd0, fault_o}, 8'd0);
    // R5 length zero behaves as one
    cfg(1'b0, 1'b0, 8'd0);
    gk_ni = 1'b0; tick(2);
    chk("R5 len0 before", {7'd0, fault_o}, 8'd0);
    tick(1);
    chk("R5 len0 fault", {7'd0, fault_o}, 8'd1);
    gk_ni = 1'b1; tick(3); clear;
    cfg(1'b0, 1'b0, 8'd32);

    // R7 brake kill
    pwm_i = 6'b001111; brake_i = 1'b1;
    bk_ni = 1'b0; tick(1);
    chk("R7 before", {7'd0, brake_o}, 8'd0);
    tick(1);
    chk("R7 brake", {7'd0, brake_o}, 8'd1);
    chk("R7 phase", {2'b0, phase_o}, {2'b0, 6'b001111});
    chk("R7 fault", {7'd0, fault_o}, 8'd0);
    cfg(1'b0, 1'b1, 8'd32);
    chk("R7 ht brake", {7'd0, brake_o}, 8'd0);
    bk_ni = 1'b1; tick(2);
    chk("R7 release", {7'd0, brake_o}, 8'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule